// File: doc/BRIEF.md
# Sixteen-bit Teaching Processor Core

This block is a small multicycle processor for a minimal 16-bit instruction set. It has sixteen 16-bit registers, an 8-bit program counter and one 256-word memory that holds both code and data. Every instruction word takes one of two layouts. The register layout has an opcode and three register indices. The immediate layout has an opcode, one register index and an 8-bit constant or address. Each instruction passes through a fetch phase, an execute phase and a writeback phase. The halt instruction stops the core.

After reset the core waits in an idle phase. The program and its data are written into memory through a valid/ready load port. A word is taken on each clock edge where both `ld_valid` and `ld_ready` are high. `ld_ready` is high only while the core is idle. Once `start` has been sampled, `ld_ready` stays low until the next reset, so back-pressure lasts for the rest of the run. A load offered while `ld_ready` is low is never taken, and the source may keep it pending. A plain combinational peek port returns any memory word, so the caller can collect results.

Top module: `rc16_core`

## Requirements
- R1: After reset the core is idle: `pc` is 0x10, `halted` is 0 and `ld_ready` is 1.
- R2: A load handshake writes `ld_data` to `ld_addr`. `ld_ready` drops on the edge that samples `start` and stays low until reset. A load offered while `ld_ready` is low leaves memory unchanged.
- R3: The opcode sits in bits 15:12. The d, s and t register indices sit in bits 11:8, 7:4 and 3:0. Opcodes 1 to 4 write R[s]+R[t], R[s]-R[t], R[s]&R[t] and R[s]^R[t] into R[d], all modulo 2^16.
- R4: Opcode 5 shifts R[s] left by R[t] and opcode 6 shifts it right logically by R[t]. Both write R[d]. A shift amount of 16 or more gives 0.
- R5: The immediate is bits 7:0. Opcode 7 writes the zero-extended immediate into R[d]. Opcode 8 loads mem[imm] into R[d]. Opcode 9 stores R[d] to mem[imm].
- R6: Opcode A loads mem[R[t]] into R[d]. Opcode B stores R[d] to mem[R[t]]. Only the low 8 bits of R[t] form the address.
- R7: R0 always reads as zero, and writes to it have no effect.
- R8: Opcode F saves the address of the next instruction into R[d] and then jumps to the immediate. Opcode E jumps to the low 8 bits of R[d].
- R9: Opcode C jumps to the immediate when R[d] is zero. Opcode D jumps when R[d], read as a signed value, is greater than zero. Otherwise execution falls through.
- R10: Opcode 0 (halt) raises `halted`. `halted` then stays high, and `pc` holds the address of the halt instruction.
- R11: A program that runs K instructions before its halt raises `halted` on the (3K+2)-th rising edge after the edge that samples `start`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin execution at the reset PC (sampled while idle) |
| ld_valid | input | 1 | Load word offered |
| ld_ready | output | 1 | Core accepts load words (idle only) |
| ld_addr | input | 8 | Load word address |
| ld_data | input | 16 | Load word data |
| peek_addr | input | 8 | Memory observation address |
| peek_data | output | 16 | Memory word at `peek_addr` (combinational) |
| halted | output | 1 | Core executed a halt |
| pc | output | 8 | Current program counter |

## Verification
A corrupted phase register shows up at once on `halted`, `ld_ready` or the timing of `halted`. A wrong cycle count from start to halt exposes a skipped or repeated phase within a single program. Faults in a register, the ALU or an address path stay hidden until a store writes the value to memory. The programs therefore store every intermediate value and read it back through the peek port after the halt. A wrong branch decision or link value changes which marker words are written and which halt address `pc` settles on, so it is visible within a few instructions.

// File: rtl/rc16_pkg.sv
package rc16_pkg;
  localparam int DATA_W = 16;
  localparam int ADDR_W = 8;
  localparam int REG_N  = 16;
  localparam int RIDX_W = $clog2(REG_N);

  typedef enum logic [3:0] {
    OP_HALT = 4'h0, OP_ADD = 4'h1, OP_SUB = 4'h2, OP_AND = 4'h3,
    OP_XOR  = 4'h4, OP_SHL = 4'h5, OP_SHR = 4'h6, OP_LDA = 4'h7,
    OP_LD   = 4'h8, OP_ST  = 4'h9, OP_LDI = 4'hA, OP_STI = 4'hB,
    OP_JZ   = 4'hC, OP_JP  = 4'hD, OP_JR  = 4'hE, OP_JAL = 4'hF
  } opcode_e;

  typedef enum logic [2:0] {
    PH_IDLE, PH_FETCH, PH_EXEC, PH_WB, PH_HALT
  } phase_e;

  typedef struct packed {
    opcode_e           op;
    logic [RIDX_W-1:0] d;
    logic [RIDX_W-1:0] s;
    logic [RIDX_W-1:0] t;
  } instr_t;
endpackage

// File: rtl/rc16_regfile.sv
module rc16_regfile #(
  parameter int W = 16,
  parameter int N = 16,
  localparam int IW = $clog2(N)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [IW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic [IW-1:0] ra_d,
  input  logic [IW-1:0] ra_s,
  input  logic [IW-1:0] ra_t,
  output logic [W-1:0]  rd_d,
  output logic [W-1:0]  rd_s,
  output logic [W-1:0]  rd_t
);
  logic [W-1:0] regs [N];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < N; i++) regs[i] <= '0;
    end else if (we && waddr != '0) begin
      regs[waddr] <= wdata;
    end
  end

  // index zero is hardwired to read zero
  assign rd_d = (ra_d == '0) ? '0 : regs[ra_d];
  assign rd_s = (ra_s == '0) ? '0 : regs[ra_s];
  assign rd_t = (ra_t == '0) ? '0 : regs[ra_t];
endmodule

// File: rtl/rc16_alu.sv
module rc16_alu import rc16_pkg::*; #(
  parameter int W = 16,
  localparam int SW = $clog2(W)
) (
  input  opcode_e      op,
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic [W-1:0] y
);
  logic big_shift;
  assign big_shift = |b[W-1:SW];

  always_comb begin
    case (op)
      OP_ADD:  y = a + b;
      OP_SUB:  y = a - b;
      OP_AND:  y = a & b;
      OP_XOR:  y = a ^ b;
      OP_SHL:  y = big_shift ? '0 : (a << b[SW-1:0]);
      OP_SHR:  y = big_shift ? '0 : (a >> b[SW-1:0]);
      default: y = '0;
    endcase
  end
endmodule

// File: rtl/rc16_mem.sv
module rc16_mem #(
  parameter int W  = 16,
  parameter int AW = 8,
  localparam int DEPTH = 1 << AW
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic [AW-1:0] raddr_a,
  output logic [W-1:0]  rdata_a,
  input  logic [AW-1:0] raddr_b,
  output logic [W-1:0]  rdata_b
);
  logic [W-1:0] cells [DEPTH];

  always_ff @(posedge clk) begin
    if (we) cells[waddr] <= wdata;
  end

  assign rdata_a = cells[raddr_a];
  assign rdata_b = cells[raddr_b];
endmodule

// File: rtl/rc16_core.sv
module rc16_core import rc16_pkg::*; #(
  parameter logic [ADDR_W-1:0] RESET_PC = 8'h10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              ld_valid,
  output logic              ld_ready,
  input  logic [ADDR_W-1:0] ld_addr,
  input  logic [DATA_W-1:0] ld_data,
  input  logic [ADDR_W-1:0] peek_addr,
  output logic [DATA_W-1:0] peek_data,
  output logic              halted,
  output logic [ADDR_W-1:0] pc
);
  localparam int PAD_W = DATA_W - ADDR_W;

  phase_e            phase;
  logic [ADDR_W-1:0] pc_q, pc_n;
  instr_t            ir;
  logic [DATA_W-1:0] res_q, res_n;
  logic              wen_q, wen_n;

  logic [ADDR_W-1:0] imm;
  logic [DATA_W-1:0] rd_val, rs_val, rt_val, alu_y, mem_rd;
  logic [ADDR_W-1:0] mem_ra, ex_wa, mem_wa;
  logic [DATA_W-1:0] mem_wd;
  logic              ex_we, mem_we;

  assign imm = {ir.s, ir.t};

  rc16_regfile #(.W(DATA_W), .N(REG_N)) u_rf (
    .clk(clk), .rst_n(rst_n),
    .we(phase == PH_WB && wen_q), .waddr(ir.d), .wdata(res_q),
    .ra_d(ir.d), .ra_s(ir.s), .ra_t(ir.t),
    .rd_d(rd_val), .rd_s(rs_val), .rd_t(rt_val)
  );

  rc16_alu #(.W(DATA_W)) u_alu (.op(ir.op), .a(rs_val), .b(rt_val), .y(alu_y));

  // port a serves fetch and data loads; port b is the peek window
  assign mem_ra = (phase == PH_FETCH) ? pc_q
                : (ir.op == OP_LDI)   ? rt_val[ADDR_W-1:0] : imm;
  assign mem_we = (phase == PH_IDLE && ld_valid) || (phase == PH_EXEC && ex_we);
  assign mem_wa = (phase == PH_IDLE) ? ld_addr : ex_wa;
  assign mem_wd = (phase == PH_IDLE) ? ld_data : rd_val;

  rc16_mem #(.W(DATA_W), .AW(ADDR_W)) u_mem (
    .clk(clk), .we(mem_we), .waddr(mem_wa), .wdata(mem_wd),
    .raddr_a(mem_ra), .rdata_a(mem_rd),
    .raddr_b(peek_addr), .rdata_b(peek_data)
  );

  always_comb begin
    res_n = '0;
    wen_n = 1'b0;
    pc_n  = pc_q;
    ex_we = 1'b0;
    ex_wa = imm;
    case (ir.op)
      OP_ADD, OP_SUB, OP_AND, OP_XOR, OP_SHL, OP_SHR: begin
        res_n = alu_y; wen_n = 1'b1;
      end
      OP_LDA: begin res_n = {{PAD_W{1'b0}}, imm}; wen_n = 1'b1; end
      OP_LD, OP_LDI: begin res_n = mem_rd; wen_n = 1'b1; end
      OP_ST:  ex_we = 1'b1;
      OP_STI: begin ex_we = 1'b1; ex_wa = rt_val[ADDR_W-1:0]; end
      OP_JZ:  if (rd_val == '0) pc_n = imm;
      OP_JP:  if ($signed(rd_val) > 0) pc_n = imm;
      OP_JR:  pc_n = rd_val[ADDR_W-1:0];
      OP_JAL: begin res_n = {{PAD_W{1'b0}}, pc_q}; wen_n = 1'b1; pc_n = imm; end
      OP_HALT: pc_n = pc_q - 1'b1;  // undo the fetch increment
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase <= PH_IDLE;
      pc_q  <= RESET_PC;
      ir    <= '0;
      res_q <= '0;
      wen_q <= 1'b0;
    end else begin
      case (phase)
        PH_IDLE:  if (start) phase <= PH_FETCH;
        PH_FETCH: begin
          ir    <= instr_t'(mem_rd);
          pc_q  <= pc_q + 1'b1;
          phase <= PH_EXEC;
        end
        PH_EXEC: begin
          res_q <= res_n;
          wen_q <= wen_n;
          pc_q  <= pc_n;
          phase <= (ir.op == OP_HALT) ? PH_HALT : PH_WB;
        end
        PH_WB:   phase <= PH_FETCH;
        PH_HALT: phase <= PH_HALT;
        default: phase <= PH_IDLE;
      endcase
    end
  end

  assign ld_ready = (phase == PH_IDLE);
  assign halted   = (phase == PH_HALT);
  assign pc       = pc_q;
endmodule

// File: rtl/rc16_core_chk.sv
module rc16_core_chk #(
  parameter logic [7:0] RESET_PC = 8'h10
) (
  input logic       clk,
  input logic       rst_n,
  input logic       start,
  input logic       ld_ready,
  input logic       halted,
  input logic [7:0] pc
);
  // R1: while idle the PC sits at its reset value
  assert_idle_pc_R1: assert property (@(posedge clk) disable iff (!rst_n)
    ld_ready |-> pc == RESET_PC);

  // R2: start closes the load port
  assert_start_closes_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_ready && start) |=> !ld_ready);

  // R2: once closed, the load port stays closed
  assert_port_stays_closed_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !ld_ready |=> !ld_ready);

  // R10: halted is sticky and freezes the PC
  assert_halt_freezes_R10: assert property (@(posedge clk) disable iff (!rst_n)
    halted |=> (halted && $stable(pc)));

  // R10: a halted core never reopens the load port
  assert_halt_not_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !(halted && ld_ready));
endmodule

bind rc16_core rc16_core_chk #(.RESET_PC(RESET_PC)) u_rc16_core_chk (
  .clk(clk), .rst_n(rst_n), .start(start),
  .ld_ready(ld_ready), .halted(halted), .pc(pc)
);

// File: tb/rc16_core_bench.sv
`timescale 1ns/1ps
module rc16_core_bench;
  localparam logic [3:0] K_HALT = 4'h0, K_ADD = 4'h1, K_SUB = 4'h2, K_AND = 4'h3,
    K_XOR = 4'h4, K_SHL = 4'h5, K_SHR = 4'h6, K_LDA = 4'h7, K_LD = 4'h8, K_ST = 4'h9,
    K_LDI = 4'hA, K_STI = 4'hB, K_JZ = 4'hC, K_JP = 4'hD, K_JR = 4'hE, K_JAL = 4'hF;

  logic clk = 0, rst_n = 0, start = 0, ld_valid = 0;
  logic ld_ready, halted;
  logic [7:0] ld_addr = 0, peek_addr = 0, pc;
  logic [15:0] ld_data = 0, peek_data;
  int n_checks = 0, n_fails = 0;
  logic [7:0] cursor;

  rc16_core u_rc16_core (
    .clk(clk), .rst_n(rst_n), .start(start), .ld_valid(ld_valid), .ld_ready(ld_ready),
    .ld_addr(ld_addr), .ld_data(ld_data), .peek_addr(peek_addr), .peek_data(peek_data),
    .halted(halted), .pc(pc)
  );

  always #2.5 clk = ~clk;

  function automatic logic [15:0] rr(logic [3:0] op, logic [3:0] d, logic [3:0] s, logic [3:0] t);
    return {op, d, s, t};
  endfunction
  function automatic logic [15:0] im(logic [3:0] op, logic [3:0] d, logic [7:0] k);
    return {op, d, k};
  endfunction

  task automatic check(string req, logic [15:0] act, logic [15:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 0; start = 0; ld_valid = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    cursor = 8'h10;
  endtask

  task automatic poke(logic [7:0] a, logic [15:0] w);
    @(negedge clk);
    ld_valid = 1; ld_addr = a; ld_data = w;
    @(negedge clk);
    ld_valid = 0;
  endtask

  task automatic emit(logic [15:0] w);
    poke(cursor, w);
    cursor = cursor + 1;
  endtask

  task automatic peek(string req, logic [7:0] a, logic [15:0] exp);
    peek_addr = a;
    #1;
    check(req, peek_data, exp);
  endtask

  task automatic run(output int edges);
    @(negedge clk);
    start = 1;
    @(negedge clk);
    start = 0;
    edges = 1;  // the edge between the two negedges sampled start... count from there
    edges = 0;
    for (int i = 0; i < 4000; i++) begin
      if (halted) break;
      @(posedge clk); #1;
      edges++;
    end
  endtask

  // run helper counting edges exactly after the start-sampling edge
  task automatic run_timed(output int edges);
    @(negedge clk);
    start = 1;
    @(posedge clk);
    @(negedge clk);
    start = 0;
    edges = 1;  // the negedge lies half a cycle after edge 0; edge 1 comes next
    edges = 0;
    for (int i = 0; i < 4000; i++) begin
      @(posedge clk); #1;
      edges++;
      if (halted) break;
    end
  endtask

  task automatic t_reset();
    do_reset();
    #1;
    check("R1 pc", {8'h00, pc}, 16'h0010);
    check("R1 halted", {15'h0, halted}, 16'h0);
    check("R1 ld_ready", {15'h0, ld_ready}, 16'h1);
  endtask

  task automatic t_alu();
    int e;
    do_reset();
    poke(8'h80, 16'hFFF0); poke(8'h81, 16'h0025);
    emit(im(K_LD, 1, 8'h80)); emit(im(K_LD, 2, 8'h81));
    emit(rr(K_ADD, 3, 1, 2)); emit(im(K_ST, 3, 8'hA0));
    emit(rr(K_SUB, 4, 2, 1)); emit(im(K_ST, 4, 8'hA1));
    emit(rr(K_AND, 5, 1, 2)); emit(im(K_ST, 5, 8'hA2));
    emit(rr(K_XOR, 6, 1, 2)); emit(im(K_ST, 6, 8'hA3));
    emit(im(K_HALT, 0, 8'h00));
    run_timed(e);
    check("R11 cycles to halt", 16'(e), 16'd32);
    peek("R3 add", 8'hA0, 16'h0015);
    peek("R3 sub", 8'hA1, 16'h0035);
    peek("R3 and", 8'hA2, 16'h0020);
    peek("R3 xor", 8'hA3, 16'hFFD5);
    check("R10 halted", {15'h0, halted}, 16'h1);
    check("R10 pc at halt", {8'h00, pc}, 16'h001A);
    // R2: load attempt while not ready must be ignored
    check("R2 ld_ready low", {15'h0, ld_ready}, 16'h0);
    poke(8'hA0, 16'hDEAD);
    repeat (4) @(negedge clk);
    peek("R2 ignored load", 8'hA0, 16'h0015);
    check("R10 pc still at halt", {8'h00, pc}, 16'h001A);
    check("R10 still halted", {15'h0, halted}, 16'h1);
  endtask

  task automatic t_shift();
    int e;
    do_reset();
    poke(8'h80, 16'h8001); poke(8'h81, 16'h0102);
    emit(im(K_LD, 1, 8'h80)); emit(im(K_LD, 9, 8'h81));
    emit(im(K_LDA, 2, 8'd3)); emit(im(K_LDA, 3, 8'd16)); emit(im(K_LDA, 4, 8'd15));
    emit(rr(K_SHL, 5, 1, 2)); emit(rr(K_SHR, 6, 1, 2));
    emit(rr(K_SHL, 7, 1, 3)); emit(rr(K_SHR, 8, 1, 4)); emit(rr(K_SHL, 10, 1, 9));
    emit(im(K_ST, 5, 8'hA0)); emit(im(K_ST, 6, 8'hA1)); emit(im(K_ST, 7, 8'hA2));
    emit(im(K_ST, 8, 8'hA3)); emit(im(K_ST, 10, 8'hA4));
    emit(im(K_HALT, 0, 8'h00));
    run_timed(e);
    check("R11 cycles to halt", 16'(e), 16'd47);
    peek("R4 shl 3", 8'hA0, 16'h0008);
    peek("R4 shr 3", 8'hA1, 16'h1000);
    peek("R4 shl 16", 8'hA2, 16'h0000);
    peek("R4 shr 15", 8'hA3, 16'h0001);
    peek("R4 shl 0x102", 8'hA4, 16'h0000);
    check("R10 pc at halt", {8'h00, pc}, 16'h001F);
  endtask

  task automatic t_mem();
    int e;
    do_reset();
    poke(8'h80, 16'h1234); poke(8'h81, 16'hBEEF); poke(8'h82, 16'h03A2);
    poke(8'hA0, 16'h0); poke(8'hA1, 16'h0); poke(8'hA2, 16'h0);
    emit(im(K_LDA, 1, 8'h7F)); emit(im(K_ST, 1, 8'hA0));
    emit(im(K_LD, 2, 8'h80)); emit(im(K_LDA, 3, 8'h81));
    emit(rr(K_LDI, 4, 0, 3)); emit(im(K_LD, 5, 8'h82));
    emit(rr(K_STI, 4, 0, 5)); emit(im(K_ST, 2, 8'hA1));
    emit(im(K_HALT, 0, 8'h00));
    run_timed(e);
    peek("R5 lda+st", 8'hA0, 16'h007F);
    peek("R5 ld+st", 8'hA1, 16'h1234);
    peek("R6 ldi+sti low-byte address", 8'hA2, 16'hBEEF);
    check("R10 pc at halt", {8'h00, pc}, 16'h0018);
  endtask

  task automatic t_r0();
    int e;
    do_reset();
    poke(8'h80, 16'h1234);
    poke(8'hA0, 16'hFFFF); poke(8'hA1, 16'hFFFF); poke(8'hA2, 16'hFFFF);
    emit(im(K_LDA, 0, 8'h55)); emit(im(K_ST, 0, 8'hA0));
    emit(im(K_LD, 0, 8'h80)); emit(im(K_ST, 0, 8'hA1));
    emit(im(K_LDA, 1, 8'h33)); emit(rr(K_ADD, 0, 1, 1));
    emit(rr(K_ADD, 2, 0, 1)); emit(im(K_ST, 2, 8'hA2));
    emit(im(K_HALT, 0, 8'h00));
    run_timed(e);
    peek("R7 lda to r0", 8'hA0, 16'h0000);
    peek("R7 ld to r0", 8'hA1, 16'h0000);
    peek("R7 add to r0", 8'hA2, 16'h0033);
  endtask

  task automatic t_jump();
    int e;
    do_reset();
    poke(8'h80, 16'h5311);
    emit(im(K_JAL, 1, 8'h30)); emit(im(K_ST, 1, 8'hA0)); emit(im(K_HALT, 0, 8'h00));
    cursor = 8'h30;
    emit(im(K_LDA, 2, 8'h77)); emit(im(K_ST, 2, 8'hA1));
    emit(im(K_LD, 3, 8'h80)); emit(rr(K_JR, 3, 0, 0));
    run_timed(e);
    peek("R8 jal link", 8'hA0, 16'h0011);
    peek("R8 jal target ran", 8'hA1, 16'h0077);
    check("R8 jr low byte return", {8'h00, pc}, 16'h0012);
  endtask

  task automatic t_branch();
    int e;
    do_reset();
    poke(8'h80, 16'h8000);
    for (int a = 8'hA0; a <= 8'hA4; a++) poke(8'(a), 16'h0);
    emit(im(K_LD, 2, 8'h80)); emit(im(K_LDA, 3, 8'h01));
    emit(im(K_JZ, 1, 8'h14)); emit(im(K_ST, 3, 8'hA0));
    emit(im(K_JZ, 3, 8'h16)); emit(im(K_ST, 3, 8'hA1));
    emit(im(K_JP, 2, 8'h18)); emit(im(K_ST, 3, 8'hA2));
    emit(im(K_JP, 3, 8'h1A)); emit(im(K_ST, 3, 8'hA3));
    emit(im(K_JP, 1, 8'h1C)); emit(im(K_ST, 3, 8'hA4));
    emit(im(K_HALT, 0, 8'h00));
    run_timed(e);
    peek("R9 jz zero taken", 8'hA0, 16'h0000);
    peek("R9 jz nonzero falls", 8'hA1, 16'h0001);
    peek("R9 jp negative falls", 8'hA2, 16'h0001);
    peek("R9 jp positive taken", 8'hA3, 16'h0000);
    peek("R9 jp zero falls", 8'hA4, 16'h0001);
    check("R10 pc at halt", {8'h00, pc}, 16'h001C);
  endtask

  initial begin
    #(5.0 * 150000);
    n_fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end

  initial begin
    t_reset();
    t_alu();
    t_shift();
    t_mem();
    t_r0();
    t_jump();
    t_branch();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end
endmodule